// File: doc/BRIEF.md
# Link Integrity Warning Timer

This block sits between the link detectors and the line drivers of a two-port media converter. When the receive link on one interface is lost, it periodically asks that interface's transmitter to go quiet. The far-end partner then sees its own link indication blink, which tells the operator that the path through the converter is broken. A single free-running cycle counter, clocked from the 25 MHz reference, sets both the repeat period and the length of the quiet window. A test-fast input switches to a shorter second pair of timing values.

The function runs only when its enable is set and the configuration allows exactly one data rate. The enable is shared with a strap that also sets an address bit. Each port is judged on its own link status. If every port has lost its link, every transmitter is held quiet for as long as that lasts. The transmitter-off requests are registered, and a port whose link returns stops being blanked on the next clock edge.

Top module: `link_warn_timer`

## Requirements
- R1: While reset is asserted, and on the first clock after reset is released with the function inactive, every bit of `txOff` is 0.
- R2: When `liwEnable` is 0, every bit of `txOff` is 0 one clock later, whatever the link inputs are, including all links down.
- R3: When `singleSpeed` is 0, the function is inactive and every bit of `txOff` is 0 one clock later, even with `liwEnable` at 1.
- R4: With the function active, the normal profile selected (`testFast` = 0), and only port p down, `txOff[p]` is 1 after clock edges j = 0 .. OFF_CYC-1 of each PERIOD_CYC-edge period and 0 for the rest of that period. Edge j = 0 is the first edge at which the function is sampled active.
- R5: With `testFast` = 1 the same pattern holds, using FAST_OFF_CYC quiet edges in every FAST_PERIOD_CYC-edge period.
- R6: A port whose `linkUp` bit is 1 has its `txOff` bit at 0 one clock later, while another port is being blanked.
- R7: With the function active and every `linkUp` bit 0, every `txOff` bit is 1 one clock later and stays 1 for as long as that condition holds.
- R8: When a blanked port's `linkUp` bit rises, its `txOff` bit is 0 after the very next clock edge, whatever the point in the period.
- R9: Making the function inactive, by clearing `liwEnable` or `singleSpeed`, returns the cycle counter to zero. When the function is next active, a new period starts at j = 0 with the port quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| liwEnable | input | 1 | Enable for the warning function, from the configuration strap |
| singleSpeed | input | 1 | 1 when the configuration allows exactly one data rate |
| testFast | input | 1 | Selects the short timing profile |
| linkUp | input | NUM_PORTS | Receive link status, one bit per interface, 1 = up |
| txOff | output | NUM_PORTS | Transmitter-off request, one bit per interface, 1 = silence the driver |

## Verification
The assertions assume that `linkUp`, `liwEnable`, `singleSpeed` and `testFast` are synchronous to `clk` and stable across each sampling edge. They also assume that the counter limits satisfy FAST_PERIOD_CYC <= PERIOD_CYC and that each quiet window is shorter than its own period. The stimulus changes inputs only one time unit after a rising edge and holds them until the next edge. It uses small timing parameters that respect these orderings, and it never changes `testFast` while the function is active.

// File: rtl/liw_pkg.sv
package liw_pkg;
  // Strobes passed from the timing control to the per-port gating.
  typedef struct packed {
    logic active;    // warning function running this cycle
    logic blankWin;  // counter lies inside the quiet window
  } liwStrobe_t;
endpackage

// File: rtl/liw_ctrl.sv
module liw_ctrl #(
  parameter int PERIOD_CYC      = 95000000,
  parameter int OFF_CYC         = 10625000,
  parameter int FAST_PERIOD_CYC = 23350000,
  parameter int FAST_OFF_CYC    = 2600000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                liwEnable,
  input  logic                singleSpeed,
  input  logic                testFast,
  output liw_pkg::liwStrobe_t strb
);
  localparam int CNT_W = $clog2(PERIOD_CYC + 1);
  localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(PERIOD_CYC - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_PERIOD_CYC - 1);
  localparam logic [CNT_W-1:0] NORM_OFF  = CNT_W'(OFF_CYC);
  localparam logic [CNT_W-1:0] FAST_OFF  = CNT_W'(FAST_OFF_CYC);
  localparam logic [CNT_W-1:0] NORM_LIM  = CNT_W'(PERIOD_CYC);

  logic             active;
  logic [CNT_W-1:0] cycCnt;
  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W-1:0] offLim;

  assign active  = liwEnable && singleSpeed;
  assign lastCnt = testFast ? FAST_LAST : NORM_LAST;
  assign offLim  = testFast ? FAST_OFF  : NORM_OFF;

  // Shared period counter; held at zero whenever the function is idle.
  always_ff @(posedge clk) begin
    if (!rstN)                 cycCnt <= '0;
    else if (!active)          cycCnt <= '0;
    else if (cycCnt >= lastCnt) cycCnt <= '0;
    else                       cycCnt <= cycCnt + 1'b1;
  end

  always_comb begin
    strb.active   = active;
    strb.blankWin = active && (cycCnt < offLim);
  end

  // R9: an idle cycle always leaves the counter at zero.
  assert_idle_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(liwEnable && singleSpeed) |=> (cycCnt == '0));

  // R4: the counter never leaves the longest period.
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    cycCnt < NORM_LIM);
endmodule

// File: rtl/liw_gate.sv
module liw_gate #(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  liw_pkg::liwStrobe_t  strb,
  input  logic [NUM_PORTS-1:0] linkUp,
  output logic [NUM_PORTS-1:0] txOff
);
  logic                 allDown;
  logic [NUM_PORTS-1:0] txNext;

  assign allDown = ~|linkUp;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gPort
    assign txNext[g] = strb.active && (allDown || (!linkUp[g] && strb.blankWin));

    // R6, R8: a port with its link present is released on the next edge.
    assert_up_released_R8: assert property (@(posedge clk) disable iff (!rstN)
      linkUp[g] |=> !txOff[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) txOff <= '0;
    else       txOff <= txNext;
  end

  // R2, R3: no blanking while the function is idle.
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.active |=> (txOff == '0));

  // R7: all links lost silences every transmitter.
  assert_all_down_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && (linkUp == '0)) |=> (&txOff));
endmodule

// File: rtl/link_warn_timer.sv
module link_warn_timer #(
  parameter int NUM_PORTS       = 2,
  parameter int PERIOD_CYC      = 95000000,
  parameter int OFF_CYC         = 10625000,
  parameter int FAST_PERIOD_CYC = 23350000,
  parameter int FAST_OFF_CYC    = 2600000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 liwEnable,
  input  logic                 singleSpeed,
  input  logic                 testFast,
  input  logic [NUM_PORTS-1:0] linkUp,
  output logic [NUM_PORTS-1:0] txOff
);
  liw_pkg::liwStrobe_t strb;

  liw_ctrl #(
    .PERIOD_CYC(PERIOD_CYC), .OFF_CYC(OFF_CYC),
    .FAST_PERIOD_CYC(FAST_PERIOD_CYC), .FAST_OFF_CYC(FAST_OFF_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .liwEnable(liwEnable),
    .singleSpeed(singleSpeed), .testFast(testFast), .strb(strb)
  );

  liw_gate #(.NUM_PORTS(NUM_PORTS)) uGate (
    .clk(clk), .rstN(rstN), .strb(strb), .linkUp(linkUp), .txOff(txOff)
  );
endmodule

// File: tb/tb_link_warn_timer.sv
`timescale 1ns/1ps
module tb_link_warn_timer;
  localparam int P  = 40;
  localparam int OF = 6;
  localparam int FP = 20;
  localparam int FO = 3;

  logic clk = 0;
  logic rstN = 0;
  logic liwEnable = 0, singleSpeed = 0, testFast = 0;
  logic [1:0] linkUp = 2'b11;
  logic [1:0] txOff;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  link_warn_timer #(.NUM_PORTS(2), .PERIOD_CYC(P), .OFF_CYC(OF),
    .FAST_PERIOD_CYC(FP), .FAST_OFF_CYC(FO)) dut (
    .clk(clk), .rstN(rstN), .liwEnable(liwEnable), .singleSpeed(singleSpeed),
    .testFast(testFast), .linkUp(linkUp), .txOff(txOff));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic go_idle();
    liwEnable = 0; singleSpeed = 1; testFast = 0; linkUp = 2'b11;
    step(); step();
  endtask

  task automatic t_reset_R1();
    rstN = 0; step(); chk("R1", txOff, 2'b00);
    rstN = 1; step(); chk("R1", txOff, 2'b00);
  endtask

  task automatic t_disabled_R2();
    liwEnable = 0; singleSpeed = 1; linkUp = 2'b00;
    for (int j = 0; j < 8; j++) begin step(); chk("R2", txOff, 2'b00); end
    go_idle();
  endtask

  task automatic t_multi_speed_R3();
    liwEnable = 1; singleSpeed = 0; linkUp = 2'b10;
    for (int j = 0; j < 8; j++) begin step(); chk("R3", txOff, 2'b00); end
    go_idle();
  endtask

  // Port 0 down, port 1 up: checks R4 pattern and R6 independence.
  task automatic t_normal_R4();
    linkUp = 2'b10; testFast = 0; singleSpeed = 1; liwEnable = 1;
    for (int j = 0; j < 2 * P; j++) begin
      step();
      chk("R4", {1'b0, txOff[0]}, {1'b0, ((j % P) < OF)});
      chk("R6", {1'b0, txOff[1]}, 2'b00);
    end
    go_idle();
  endtask

  task automatic t_fast_R5();
    linkUp = 2'b01; testFast = 1; singleSpeed = 1; liwEnable = 1;
    for (int j = 0; j < 2 * FP; j++) begin
      step();
      chk("R5", txOff, {((j % FP) < FO), 1'b0});
    end
    go_idle();
  endtask

  task automatic t_all_down_R7();
    linkUp = 2'b00; singleSpeed = 1; liwEnable = 1;
    for (int j = 0; j < P + 5; j++) begin step(); chk("R7", txOff, 2'b11); end
    go_idle();
  endtask

  task automatic t_return_R8();
    linkUp = 2'b10; singleSpeed = 1; liwEnable = 1;
    step(); step();
    chk("R8", txOff, 2'b01);
    linkUp = 2'b11;
    step(); chk("R8", txOff, 2'b00);
    go_idle();
  endtask

  task automatic t_restart_R9();
    linkUp = 2'b10; singleSpeed = 1; liwEnable = 1;
    for (int j = 0; j < 10; j++) step();
    chk("R9", txOff, 2'b00);            // j = 9 lies outside the window
    singleSpeed = 0; step(); chk("R9", txOff, 2'b00);
    singleSpeed = 1;
    for (int j = 0; j < OF + 1; j++) begin
      step();
      chk("R9", txOff, {1'b0, (j < OF)});
    end
    go_idle();
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step();
    t_reset_R1();
    t_disabled_R2();
    t_multi_speed_R3();
    t_normal_R4();
    t_fast_R5();
    t_all_down_R7();
    t_return_R8();
    t_restart_R9();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule